// File: doc/BRIEF.md
# Dual-output compare waveform timer

This block is one timer channel used as a two-output waveform generator. A single up-counter, advanced by a selectable tick, runs from zero up to the period compare value and wraps back to zero. That value sets one shared period. Each of the two outputs has its own switch-point compare value and its own table of actions. The table says what the output does when the counter meets its own compare value, when the counter meets the period value, and when software triggers the channel. Programming "set on period, clear on own compare" gives a normal PWM. Swapping the two actions gives an inverted one. Leaving both compare actions empty holds the output at its trigger level, which gives a steady 0% or 100% duty.

Software reaches the block through two paths. A small register write port loads the mode word and the three compare values. Three command strobes start the count tick, stop it, and trigger. A trigger clears the counter and applies each output's trigger action in the same cycle. The tick is one of four divisions of the main clock, taken from a free-running prescaler, or a slow-clock enable pulse that is already synchronized to the main clock. Everything runs in the main clock domain.

Top module: `cmpwave_timer`

## Requirements
- R1: During and after reset both outputs are low, the counter is zero, the counter is stopped, and the mode word and all compare values are zero.
- R2: Clock select values 0, 1, 2 and 3 (mode bits [2:0]) advance a running counter exactly once every 2, 8, 32 and 128 main clocks. Values 4 to 7 advance it once per cycle in which slow_tick is high. The prescaler runs freely from reset, so any window of N times the division holds exactly N advances.
- R3: On each advance, a counter equal to the period value returns to zero, and any other counter value increments by one. The period is therefore period value + 1 advances.
- R4: Action codes are 00 keep, 01 set, 10 clear and 11 toggle. Mode bits [8:3] hold output A's fields and bits [14:9] hold output B's fields. Within each 6-bit group, the own-compare action is in the low two bits, the period-match action is in the middle two bits and the trigger action is in the high two bits. An own match acts only on an advance.
- R5: When several events hit one output in the same cycle, only the highest one present acts, even if its action is keep. The trigger is highest, then the period match, then the own compare.
- R6: A trigger strobe clears the counter and applies each output's trigger action at the next clock edge, whether the counter is running or stopped.
- R7: cmd_clken starts the counter and cmd_clkdis stops it. If both arrive together, the counter stops. A stopped counter holds its value, and both outputs hold their levels until the next trigger.
- R8: An output whose own-compare and period actions are both keep stays at the level its last trigger gave it.
- R9: Register writes use wr_sel 0 for the mode word, 1 for compare A, 2 for compare B and 3 for the period. A written value is used from the next clock edge on. A compare value of zero is matched like any other value, and a period value of zero holds the counter at zero.
- R10: Output B follows compare B and its own fields, independent of output A, while sharing the counter and the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | Synchronized slow-clock enable pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mode, 1 compare A, 2 compare B, 3 period |
| wr_data | input | CNT_W | Write data; the mode word takes the low 15 bits |
| cmd_clken | input | 1 | Start the counter |
| cmd_clkdis | input | 1 | Stop the counter (wins over start) |
| cmd_swtrg | input | 1 | Trigger: clear the counter and force the outputs |
| wave_a | output | 1 | Waveform output A |
| wave_b | output | 1 | Waveform output B |
| cnt_value | output | CNT_W | Current counter value |
| cnt_running | output | 1 | Counter is started |

## Verification
The bench builds the block with a 16-bit counter, short periods of a few ticks, and switch points placed before the period, at the period and at zero. With these values every one of the 64 action-table combinations for each output cycles through many full periods in a few thousand clocks. A cycle-accurate model in the bench, written from the requirements, predicts both outputs, the counter and the run flag on every cycle. Windows of N times each division confirm the exact tick rate whatever the prescaler phase. Triggers land at shifting offsets so that they coincide with compare events, and the bench also covers simultaneous start and stop, a zero period and a zero compare.

// File: rtl/cmpwave_pkg.sv
package cmpwave_pkg;

  localparam int PRESC_W = 7;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_FLIP = 2'b11
  } act_e;

  // per-output action table: trigger action high, own-compare action low
  typedef struct packed {
    act_e sw;
    act_e per;
    act_e own;
  } out_act_t;

  typedef struct packed {
    out_act_t b;
    out_act_t a;
    logic [2:0] csel;
  } mode_t;

  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_CMPA = 2'd1;
  localparam logic [1:0] SEL_CMPB = 2'd2;
  localparam logic [1:0] SEL_PER  = 2'd3;

  function automatic logic apply_act(input act_e a, input logic cur);
    case (a)
      ACT_SET:  return 1'b1;
      ACT_CLR:  return 1'b0;
      ACT_FLIP: return ~cur;
      default:  return cur;
    endcase
  endfunction

  function automatic act_e pick_act(input logic sw_hit, input logic per_hit,
                                    input logic own_hit, input out_act_t acts);
    if (sw_hit)  return acts.sw;
    if (per_hit) return acts.per;
    if (own_hit) return acts.own;
    return ACT_KEEP;
  endfunction

  // division 2^(2*idx+1): hit when the low (2*idx+1) prescaler bits are all ones
  function automatic logic div_hit(input logic [PRESC_W-1:0] p, input logic [1:0] idx);
    logic [PRESC_W-1:0] mask;
    mask = PRESC_W'((32'd1 << (2 * int'(idx) + 1)) - 1);
    return (p & mask) == mask;
  endfunction

endpackage

// File: rtl/cmpwave_prescale.sv
module cmpwave_prescale
  import cmpwave_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_tick,
  input  logic [2:0] csel,
  output logic       tick
);

  logic [PRESC_W-1:0] presc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_q <= '0;
    else        presc_q <= presc_q + 1'b1;
  end

  assign tick = csel[2] ? slow_tick : div_hit(presc_q, csel[1:0]);

endmodule

// File: rtl/cmpwave_counter.sv
module cmpwave_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             restart,
  input  logic [CNT_W-1:0] top_val,
  output logic [CNT_W-1:0] cnt,
  output logic             at_top
);

  assign at_top = (cnt == top_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (advance) cnt <= at_top ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/cmpwave_output.sv
module cmpwave_output
  import cmpwave_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  out_act_t acts,
  input  logic     sw_hit,
  input  logic     per_hit,
  input  logic     own_hit,
  output logic     wave
);

  act_e chosen;
  assign chosen = pick_act(sw_hit, per_hit, own_hit, acts);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave <= 1'b0;
    else        wave <= apply_act(chosen, wave);
  end

endmodule

// File: rtl/cmpwave_timer.sv
module cmpwave_timer
  import cmpwave_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             cmd_clken,
  input  logic             cmd_clkdis,
  input  logic             cmd_swtrg,
  output logic             wave_a,
  output logic             wave_b,
  output logic [CNT_W-1:0] cnt_value,
  output logic             cnt_running
);

  localparam int N_OUT  = 2;
  localparam int MODE_W = $bits(mode_t);

  mode_t            mode_q;
  logic [CNT_W-1:0] cmp_q [N_OUT];
  logic [CNT_W-1:0] period_q;
  logic             run_q;

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      period_q <= '0;
      cmp_q[0] <= '0;
      cmp_q[1] <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_MODE: mode_q   <= mode_t'(wr_data[MODE_W-1:0]);
        SEL_CMPA: cmp_q[0] <= wr_data;
        SEL_CMPB: cmp_q[1] <= wr_data;
        default:  period_q <= wr_data;
      endcase
    end
  end

  // run flag: stop wins over start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= 1'b0;
    else if (cmd_clkdis) run_q <= 1'b0;
    else if (cmd_clken)  run_q <= 1'b1;
  end

  // named internal events
  logic             presc_tick;
  logic             count_tick;
  logic             match_c;
  logic             csel_div;
  logic [CNT_W-1:0] cnt_q;
  logic [N_OUT-1:0] own_match;
  logic [N_OUT-1:0] wave_q;
  logic [1:0]       sw_act_a;
  logic [1:0]       sw_act_b;
  out_act_t         acts [N_OUT];

  assign csel_div   = ~mode_q.csel[2];
  assign count_tick = presc_tick & run_q;
  assign sw_act_a   = mode_q.a.sw;
  assign sw_act_b   = mode_q.b.sw;
  assign acts[0]    = mode_q.a;
  assign acts[1]    = mode_q.b;

  cmpwave_prescale u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_tick (slow_tick),
    .csel      (mode_q.csel),
    .tick      (presc_tick)
  );

  cmpwave_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (count_tick),
    .restart (cmd_swtrg),
    .top_val (period_q),
    .cnt     (cnt_q),
    .at_top  (match_c)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    assign own_match[g] = (cnt_q == cmp_q[g]);

    cmpwave_output u_wave (
      .clk     (clk),
      .rst_n   (rst_n),
      .acts    (acts[g]),
      .sw_hit  (cmd_swtrg),
      .per_hit (count_tick & match_c),
      .own_hit (count_tick & own_match[g]),
      .wave    (wave_q[g])
    );
  end

  assign wave_a      = wave_q[0];
  assign wave_b      = wave_q[1];
  assign cnt_value   = cnt_q;
  assign cnt_running = run_q;

endmodule

// File: rtl/cmpwave_checker.sv
module cmpwave_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_clken,
  input logic             cmd_clkdis,
  input logic             cmd_swtrg,
  input logic             presc_tick,
  input logic             count_tick,
  input logic             match_c,
  input logic             csel_div,
  input logic [1:0]       sw_act_a,
  input logic [1:0]       sw_act_b,
  input logic [CNT_W-1:0] cnt_value,
  input logic             wave_a,
  input logic             wave_b,
  input logic             cnt_running
);

  p_div_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (presc_tick && csel_div) |=> !(presc_tick && csel_div));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_tick && match_c && !cmd_swtrg) |=> (cnt_value == '0));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_tick && !match_c && !cmd_swtrg) |=>
      (cnt_value == CNT_W'($past(cnt_value) + 1'b1)));

  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_swtrg |=> (cnt_value == '0));

  p_force_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_swtrg && sw_act_a == 2'b01) |=> wave_a);

  p_force_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_swtrg && sw_act_b == 2'b10) |=> !wave_b);

  p_hold_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_running && !cmd_swtrg) |=> $stable(cnt_value));

  p_hold_wave_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_running && !cmd_swtrg) |=> ($stable(wave_a) && $stable(wave_b)));

  p_stop_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clkdis |=> !cnt_running);

  p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clken && !cmd_clkdis) |=> cnt_running);

endmodule

bind cmpwave_timer cmpwave_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_clken   (cmd_clken),
  .cmd_clkdis  (cmd_clkdis),
  .cmd_swtrg   (cmd_swtrg),
  .presc_tick  (presc_tick),
  .count_tick  (count_tick),
  .match_c     (match_c),
  .csel_div    (csel_div),
  .sw_act_a    (sw_act_a),
  .sw_act_b    (sw_act_b),
  .cnt_value   (cnt_value),
  .wave_a      (wave_a),
  .wave_b      (wave_b),
  .cnt_running (cnt_running)
);

// File: tb/cmpwave_timer_test.sv
`timescale 1ns/1ps
module cmpwave_timer_test;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         slow_tick = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic         cmd_clken = 1'b0;
  logic         cmd_clkdis = 1'b0;
  logic         cmd_swtrg = 1'b0;
  logic         wave_a, wave_b, cnt_running;
  logic [W-1:0] cnt_value;

  always #2.5 clk = ~clk;

  cmpwave_timer #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cmd_clken(cmd_clken), .cmd_clkdis(cmd_clkdis), .cmd_swtrg(cmd_swtrg),
    .wave_a(wave_a), .wave_b(wave_b), .cnt_value(cnt_value), .cnt_running(cnt_running)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  bit    mon_on = 1'b0;
  string cur_tag = "R1";

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model, written from the requirements
  int         m_presc;
  bit         m_run;
  logic [W-1:0] m_cnt;
  logic       m_wave [2];
  logic [14:0] m_mode;
  logic [W-1:0] m_cmp [3];

  always @(posedge clk) begin
    logic tk, adv;
    logic [1:0] act;
    logic [2:0] sel;
    int divn;
    logic nw [2];
    if (!rst_n) begin
      m_presc = 0; m_run = 0; m_cnt = '0; m_mode = '0;
      m_wave[0] = 0; m_wave[1] = 0;
      m_cmp[0] = '0; m_cmp[1] = '0; m_cmp[2] = '0;
    end else begin
      sel = m_mode[2:0];
      if (sel >= 3'd4) tk = slow_tick;
      else begin
        divn = 2 << (2 * int'(sel));
        tk = ((m_presc % divn) == divn - 1);
      end
      adv = tk && m_run;
      for (int k = 0; k < 2; k++) begin
        if (cmd_swtrg) act = m_mode[7 + 6*k +: 2];
        else if (adv && m_cnt == m_cmp[2]) act = m_mode[5 + 6*k +: 2];
        else if (adv && m_cnt == m_cmp[k]) act = m_mode[3 + 6*k +: 2];
        else act = 2'b00;
        case (act)
          2'b01:   nw[k] = 1'b1;
          2'b10:   nw[k] = 1'b0;
          2'b11:   nw[k] = !m_wave[k];
          default: nw[k] = m_wave[k];
        endcase
      end
      if (cmd_swtrg) m_cnt = '0;
      else if (adv) m_cnt = (m_cnt == m_cmp[2]) ? '0 : m_cnt + 1'b1;
      if (cmd_clkdis) m_run = 0;
      else if (cmd_clken) m_run = 1;
      if (wr_en) begin
        if (wr_sel == 2'd0) m_mode = wr_data[14:0];
        else m_cmp[wr_sel - 1] = wr_data;
      end
      m_presc = (m_presc + 1) % 128;
      m_wave[0] = nw[0]; m_wave[1] = nw[1];
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (mon_on) begin
      chk(wave_a === m_wave[0], {cur_tag, " wave_a"}, wave_a, m_wave[0]);
      chk(wave_b === m_wave[1], {cur_tag, " wave_b R10"}, wave_b, m_wave[1]);
      chk(cnt_value === m_cnt, {cur_tag, " count"}, cnt_value, m_cnt);
      chk(cnt_running === m_run, {cur_tag, " running"}, cnt_running, m_run);
    end
  end

  function automatic logic [W-1:0] mk_mode(input logic [2:0] sel, input logic [5:0] a,
                                           input logic [5:0] b);
    return W'({b, a, sel});
  endfunction

  task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic cmd(input bit en, input bit dis, input bit sw);
    @(negedge clk); cmd_clken = en; cmd_clkdis = dis; cmd_swtrg = sw;
    @(negedge clk); cmd_clken = 0; cmd_clkdis = 0; cmd_swtrg = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired in %s", cur_tag);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    // R1 reset state
    idle(3);
    chk(wave_a === 1'b0, "R1 wave_a", wave_a, 0);
    chk(wave_b === 1'b0, "R1 wave_b", wave_b, 0);
    chk(cnt_value === '0, "R1 count", cnt_value, 0);
    chk(cnt_running === 1'b0, "R1 running", cnt_running, 0);
    @(negedge clk); rst_n = 1'b1;
    mon_on = 1'b1;
    idle(5);

    // R2 tick rate for each division and the slow enable
    cur_tag = "R2";
    wr(2'd3, 16'hFFFF);
    for (int s = 0; s < 4; s++) begin
      int n;
      n = 2 << (2 * s);
      wr(2'd0, mk_mode(3'(s), 6'd0, 6'd0));
      cmd(1, 0, 1);
      v = cnt_value;
      idle(n * 20);
      chk(cnt_value - v == 20, "R2 divided tick count", cnt_value - v, 20);
    end
    wr(2'd0, mk_mode(3'd4, 6'd0, 6'd0));
    cmd(1, 0, 1);
    v = cnt_value;
    for (int p = 0; p < 10; p++) begin
      idle(6);
      slow_tick = 1'b1; @(negedge clk); slow_tick = 1'b0;
    end
    chk(cnt_value - v == 10, "R2 slow tick count", cnt_value - v, 10);
    cmd(0, 1, 0);

    // R3 wrap at the period value
    cur_tag = "R3";
    wr(2'd0, mk_mode(3'd0, 6'd0, 6'd0));
    wr(2'd3, 16'd5);
    cmd(1, 0, 1);
    begin
      int mx; bit saw0;
      mx = 0; saw0 = 0;
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        if (int'(cnt_value) > mx) mx = int'(cnt_value);
        if (cnt_value == 0 && c > 20) saw0 = 1;
      end
      chk(mx == 5, "R3 highest count equals period value", mx, 5);
      chk(saw0, "R3 counter returns to zero", saw0, 1);
    end

    // R4 / R10 every action table for both outputs
    cur_tag = "R4";
    wr(2'd1, 16'd2);
    wr(2'd2, 16'd4);
    for (int combo = 0; combo < 64; combo++) begin
      wr(2'd0, mk_mode(3'd0, 6'(combo), 6'(63 - combo)));
      cmd(1, 0, 1);
      idle(26);
    end

    // R5 priority: period match beats own compare at the same count
    cur_tag = "R5";
    wr(2'd1, 16'd3);
    wr(2'd3, 16'd3);
    wr(2'd0, mk_mode(3'd0, {2'b10, 2'b01, 2'b10}, {2'b01, 2'b10, 2'b01}));
    cmd(1, 0, 1);
    idle(20);
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      chk(wave_a === 1'b1, "R5 period action wins over own compare", wave_a, 1);
    end
    // trigger at shifting offsets, colliding with compare events
    wr(2'd1, 16'd1);
    wr(2'd2, 16'd2);
    wr(2'd0, mk_mode(3'd0, {2'b11, 2'b11, 2'b11}, {2'b01, 2'b10, 2'b11}));
    for (int off = 0; off < 16; off++) begin
      cmd(1, 0, 1);
      idle(off);
      cmd(0, 0, 1);
      idle(3);
    end

    // R6 trigger while stopping: counter cleared, levels forced
    cur_tag = "R6";
    wr(2'd3, 16'd9);
    wr(2'd0, mk_mode(3'd0, {2'b01, 2'b10, 2'b10}, {2'b10, 2'b01, 2'b01}));
    cmd(1, 0, 0);
    idle(11);
    cmd(0, 1, 1);
    chk(cnt_value === '0, "R6 counter cleared", cnt_value, 0);
    chk(wave_a === 1'b1, "R6 A forced set", wave_a, 1);
    chk(wave_b === 1'b0, "R6 B forced clear", wave_b, 0);
    chk(cnt_running === 1'b0, "R7 stopped", cnt_running, 0);
    idle(50);
    chk(cnt_value === '0 && wave_a === 1'b1 && wave_b === 1'b0,
        "R7 held while stopped", {cnt_value, wave_a, wave_b}, 2);

    // R7 start and stop together, and hold mid-count
    cur_tag = "R7";
    wr(2'd3, 16'd1000);
    cmd(1, 1, 0);
    chk(cnt_running === 1'b0, "R7 stop wins over start", cnt_running, 0);
    cmd(1, 0, 0);
    idle(30);
    cmd(0, 1, 0);
    v = cnt_value;
    chk(v != 0, "R7 counter advanced before stop", v, 1);
    idle(40);
    chk(cnt_value === v, "R7 count held", cnt_value, v);

    // R8 no compare actions: steady trigger levels
    cur_tag = "R8";
    wr(2'd3, 16'd4);
    wr(2'd0, mk_mode(3'd0, {2'b01, 2'b00, 2'b00}, {2'b10, 2'b00, 2'b00}));
    cmd(1, 0, 1);
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      chk(wave_a === 1'b1 && wave_b === 1'b0, "R8 steady 100%/0% levels",
          {wave_a, wave_b}, 2);
    end

    // R9 zero compare and zero period
    cur_tag = "R9";
    wr(2'd1, 16'd0);
    wr(2'd3, 16'd6);
    wr(2'd0, mk_mode(3'd0, {2'b10, 2'b10, 2'b01}, 6'd0));
    cmd(1, 0, 1);
    idle(2);
    chk(wave_a === 1'b1, "R9 compare at zero sets output", wave_a, 1);
    idle(30);
    wr(2'd3, 16'd0);
    wr(2'd0, mk_mode(3'd0, {2'b00, 2'b11, 2'b00}, 6'd0));
    cmd(1, 0, 1);
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      chk(cnt_value === '0, "R9 zero period holds counter", cnt_value, 0);
    end

    mon_on = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule